// File: doc/BRIEF.md
# Instruction RAM Byte-Window Loader

This block lets a host fill and inspect a sequencer's instruction memory through a narrow byte-wide register window. The memory holds 512 words of 32 bits. The host sets a 9-bit word address by writing two registers: a low byte register and a high register in which only bit 0 matters. It then streams bytes through the window. Four successive window writes build one instruction word, least significant byte first. The word is written to memory in a single commit when the fourth byte arrives, and the word address then steps by one.

Reads through the window return the bytes of the addressed word in the same order and advance the byte position and address the same way writes do. A control register holds a load-enable bit, and window writes are dropped while it is clear. Instruction execution is not part of this block.

Top module: `imem_byte_loader`

## Requirements
- R1: After reset the low address register reads 0, the high address register reads 0 and the control register reads 0 (load enable off).
- R2: With load enable set, four window writes (regSel 0) store one word at the current address, with the first byte in bits 7:0 and the fourth byte in bits 31:24.
- R3: The memory word is unchanged until the fourth byte of a word has been written. An interrupted word leaves the old contents intact.
- R4: The word address is unchanged after the first, second and third byte of a word and increments by one after the fourth.
- R5: Only bit 0 of a write to the high address register (regSel 2) is kept as address bit 8. That register reads back with bits 7:1 as zero.
- R6: Writing the low (regSel 1) or high (regSel 2) address register sets the byte position back to the least significant byte.
- R7: While the control register (regSel 3) bit 0 is clear, window writes change neither memory, address nor byte position.
- R8: Window reads with regRdEn return the bytes of the current word least significant first, and advance the byte position and address exactly as writes do. regRdData for regSel 1 returns address bits 7:0.
- R9: The word address wraps from 511 to 0 after the last byte, for both writes and reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 2 | Register select: 0 window, 1 address low, 2 address high, 3 control |
| regWrEn | input | 1 | Write strobe for the selected register; takes priority over regRdEn |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe; a window read advances the byte position |
| regRdData | output | 8 | Read data of the selected register, combinational on current state |

## Verification
Every write and every window-read side effect lands on the rising edge that samples the strobe. regRdData is combinational on the state after that edge, so a value is due in the cycle after its stimulus. The bench drives each access on a falling edge and samples regRdData one nanosecond later, which is after the previous access has been committed and before the current one is. A full sweep writes and then reads back all 512 words with an arithmetic pattern. This covers the step and wrap of the address. Targeted sequences then interrupt words part way through, toggle load enable and write the high register with stray bits.

// File: rtl/imem_loader_pkg.sv
package imem_loader_pkg;
  // register select codes
  localparam logic [1:0] SEL_WINDOW  = 2'd0;
  localparam logic [1:0] SEL_ADDR_LO = 2'd1;
  localparam logic [1:0] SEL_ADDR_HI = 2'd2;
  localparam logic [1:0] SEL_CTRL    = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic laneWrite;   // accepted window write
    logic commitWord;  // last lane written: store word
    logic stepAddr;    // last lane accessed: advance address
    logic loadAddrLo;
    logic loadAddrHi;
  } loaderStrobes_t;
endpackage

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import imem_loader_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic             ctrlBit,
  output loaderStrobes_t   strobes,
  output logic [IDX_W-1:0] byteIdx,
  output logic             loadEn
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

  logic winWr, winRd, lastLane, addrWr;

  always_comb begin
    winWr    = regWrEn && (regSel == SEL_WINDOW) && loadEn;
    winRd    = !regWrEn && regRdEn && (regSel == SEL_WINDOW);
    lastLane = (byteIdx == LAST_IDX);
    addrWr   = regWrEn && ((regSel == SEL_ADDR_LO) || (regSel == SEL_ADDR_HI));

    strobes.laneWrite  = winWr;
    strobes.commitWord = winWr && lastLane;
    strobes.stepAddr   = (winWr || winRd) && lastLane;
    strobes.loadAddrLo = regWrEn && (regSel == SEL_ADDR_LO);
    strobes.loadAddrHi = regWrEn && (regSel == SEL_ADDR_HI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (addrWr) begin
      byteIdx <= '0;
    end else if (winWr || winRd) begin
      byteIdx <= lastLane ? '0 : byteIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadEn <= 1'b0;
    end else if (regWrEn && (regSel == SEL_CTRL)) begin
      loadEn <= ctrlBit;
    end
  end
endmodule

// File: rtl/loader_dp.sv
module loader_dp
  import imem_loader_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4,
  parameter int ADDR_W = 9,
  localparam int IDX_W  = $clog2(LANES),
  localparam int WORD_W = DATA_W * LANES,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int HI_W   = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  loaderStrobes_t    strobes,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic              loadEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] wordAddr
);
  logic [DATA_W-1:0] laneBuf [LANES-1];
  logic [WORD_W-1:0] commitVal;
  logic [WORD_W-1:0] curWord;
  logic [DATA_W-1:0] windowByte;
  logic [WORD_W-1:0] mem [DEPTH];

  // word address register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr <= '0;
    end else if (strobes.loadAddrLo) begin
      wordAddr[DATA_W-1:0] <= regWrData;
    end else if (strobes.loadAddrHi) begin
      wordAddr[ADDR_W-1:DATA_W] <= regWrData[HI_W-1:0];
    end else if (strobes.stepAddr) begin
      wordAddr <= wordAddr + 1'b1;
    end
  end

  // staging lanes for all but the last byte
  for (genvar g = 0; g < LANES - 1; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneBuf[g] <= '0;
      end else if (strobes.laneWrite && (byteIdx == IDX_W'(g))) begin
        laneBuf[g] <= regWrData;
      end
    end
  end

  always_comb begin
    commitVal = '0;
    for (int i = 0; i < LANES - 1; i++) begin
      commitVal[i*DATA_W +: DATA_W] = laneBuf[i];
    end
    commitVal[WORD_W-1 -: DATA_W] = regWrData;
  end

  // instruction memory, one full-word write per commit
  always_ff @(posedge clk) begin
    if (strobes.commitWord) begin
      mem[wordAddr] <= commitVal;
    end
  end

  always_comb begin
    curWord    = mem[wordAddr];
    windowByte = curWord[byteIdx*DATA_W +: DATA_W];
    unique case (regSel)
      SEL_WINDOW:  regRdData = windowByte;
      SEL_ADDR_LO: regRdData = wordAddr[DATA_W-1:0];
      SEL_ADDR_HI: regRdData = {{(DATA_W-HI_W){1'b0}}, wordAddr[ADDR_W-1:DATA_W]};
      default:     regRdData = {{(DATA_W-1){1'b0}}, loadEn};
    endcase
  end
endmodule

// File: rtl/imem_byte_loader.sv
module imem_byte_loader
  import imem_loader_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4,
  parameter int ADDR_W = 9,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData
);
  loaderStrobes_t    strobes;
  logic [IDX_W-1:0]  byteIdx;
  logic [ADDR_W-1:0] wordAddr;
  logic              loadEn;

  loader_ctrl #(.LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .ctrlBit(regWrData[0]), .strobes(strobes),
    .byteIdx(byteIdx), .loadEn(loadEn)
  );

  loader_dp #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteIdx(byteIdx),
    .loadEn(loadEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .wordAddr(wordAddr)
  );
endmodule

// File: rtl/imem_loader_chk.sv
module imem_loader_chk #(
  parameter int DATA_W = 8,
  parameter int LANES  = 4,
  parameter int ADDR_W = 9,
  localparam int IDX_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regSel,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [IDX_W-1:0]  byteIdx,
  input logic [ADDR_W-1:0] wordAddr,
  input logic              loadEn
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd0 && loadEn && byteIdx != LAST_IDX) |=> $stable(wordAddr));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd0 && loadEn && byteIdx == LAST_IDX)
      |=> (wordAddr == ADDR_W'($past(wordAddr) + 1'b1)) && (byteIdx == '0));

  // R6
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regSel == 2'd1 || regSel == 2'd2)) |=> (byteIdx == '0));

  // R7
  gated_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd0 && !loadEn) |=> ($stable(byteIdx) && $stable(wordAddr)));

  // R5
  hi_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd2)
      |=> (wordAddr[ADDR_W-1] == $past(regWrData[0])) && $stable(wordAddr[DATA_W-1:0]));

  // R8
  read_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && regRdEn && regSel == 2'd0 && byteIdx == LAST_IDX)
      |=> (wordAddr == ADDR_W'($past(wordAddr) + 1'b1)) && (byteIdx == '0));
endmodule

bind imem_byte_loader imem_loader_chk #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regWrData(regWrData), .byteIdx(byteIdx), .wordAddr(wordAddr), .loadEn(loadEn)
);

// File: tb/test_imem_byte_loader.sv
module test_imem_byte_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  imem_byte_loader i_imem_byte_loader (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  function automatic logic [31:0] pat(int a);
    logic [31:0] v;
    v = 32'(a) * 32'h0100_0193;
    return v ^ 32'hC3A5_0F1E ^ {32'(a) << 23};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWrEn = 1'b1; regRdEn = 1'b0; regWrData = d;
  endtask

  task automatic rd(logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWrEn = 1'b0; regRdEn = 1'b1;
    #1 d = regRdData;
  endtask

  task automatic setAddr(int a);
    wr(2'd1, 8'(a));
    wr(2'd2, {7'd0, 1'(a >> 8)});
  endtask

  task automatic writeWord(logic [31:0] w);
    for (int b = 0; b < 4; b++) wr(2'd0, w[8*b +: 8]);
  endtask

  task automatic readWord(output logic [31:0] w);
    logic [7:0] x;
    for (int b = 0; b < 4; b++) begin
      rd(2'd0, x);
      w[8*b +: 8] = x;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] b8;
    logic [31:0] w32;
    logic [31:0] nv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd1, b8); check("R1 addr lo", b8, 0);
    rd(2'd2, b8); check("R1 addr hi", b8, 0);
    rd(2'd3, b8); check("R1 ctrl", b8, 0);

    wr(2'd3, 8'h01);
    rd(2'd3, b8); check("R7 ctrl set", b8, 1);

    // fill sweep: R2, R4, R9
    setAddr(0);
    for (int a = 0; a < 512; a++) begin
      if (a == 5) begin
        for (int b = 0; b < 3; b++) begin
          wr(2'd0, pat(a) >> (8*b));
          rd(2'd1, b8); check("R4 hold mid-word", b8, 5);
        end
        wr(2'd0, pat(a) >> 24);
      end else begin
        writeWord(pat(a));
      end
      rd(2'd1, b8); check("R4 step lo", b8, 32'((a + 1) % 256));
    end
    rd(2'd2, b8); check("R9 wrap hi", b8, 0);

    // read sweep: R8, R2, R9
    setAddr(0);
    for (int a = 0; a < 512; a++) begin
      readWord(w32); check("R8 R2 readback", w32, pat(a));
    end
    rd(2'd1, b8); check("R9 read wrap lo", b8, 0);
    rd(2'd2, b8); check("R9 read wrap hi", b8, 0);

    // R3 interrupted word, R6 index reset by address write
    nv = 32'hDEAD_BEEF;
    setAddr(300);
    for (int b = 0; b < 3; b++) wr(2'd0, nv[8*b +: 8]);
    rd(2'd1, b8); check("R4 partial lo", b8, 44);
    wr(2'd1, 8'd44);
    readWord(w32); check("R3 no partial commit", w32, pat(300));
    setAddr(300);
    writeWord(nv);
    setAddr(300);
    readWord(w32); check("R2 overwrite", w32, nv);

    setAddr(20);
    rd(2'd0, b8); rd(2'd0, b8);
    wr(2'd2, 8'h00);
    readWord(w32); check("R6 hi write resets lane", w32, pat(20));
    setAddr(21);
    rd(2'd0, b8);
    wr(2'd1, 8'd21);
    readWord(w32); check("R6 lo write resets lane", w32, pat(21));

    // R5 high register keeps bit 0 only
    wr(2'd1, 8'h33);
    wr(2'd2, 8'hFF);
    rd(2'd2, b8); check("R5 hi odd", b8, 1);
    rd(2'd1, b8); check("R5 lo kept", b8, 8'h33);
    wr(2'd2, 8'hFE);
    rd(2'd2, b8); check("R5 hi even", b8, 0);

    // R7 writes dropped with load enable clear
    wr(2'd3, 8'h00);
    setAddr(10);
    writeWord(32'h1234_5678);
    rd(2'd1, b8); check("R7 addr unchanged", b8, 10);
    readWord(w32); check("R7 memory unchanged", w32, pat(10));
    wr(2'd3, 8'h01);

    // R9 wrap via writes from 511
    setAddr(511);
    writeWord(32'hA5A5_5A5A);
    rd(2'd2, b8); check("R9 write wrap hi", b8, 0);
    rd(2'd1, b8); check("R9 write wrap lo", b8, 0);
    setAddr(511);
    readWord(w32); check("R2 top word", w32, 32'hA5A5_5A5A);

    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
    summary();
  end
endmodule